// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

This block is a seven-pin general-purpose I/O port whose behaviour is set by a small bank of registers on a simple synchronous bus. A host programs each pin's direction, its polarity inversion and whether it drives a steady level or a timed pulse. It can read the pin levels back, with inversion applied, and read the stored output value. The pad receives an output-enable and an output-value per pin.

While reset is held, the block can record the synchronized pin levels into a snapshot register. The snapshot keeps its value after reset is released. Its three low bits are exported as a device address, so board strapping on those pins can select the address a serial host interface answers to. The serial framing, the pads and any other ports sit outside this block.

Register map (3-bit address, 8-bit data, pins in bits 6..0, bit 7 always reads 0):

| Address | Register |
|---|---|
| 0 | pin level view (read-only) |
| 1 | output data |
| 2 | polarity |
| 3 | direction |
| 4 | output style |
| 5 | reset snapshot (read-only) |
| 6, 7 | unused |

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the registers read as follows: output data 0x00, polarity 0x70, direction 0x7F, style 0x00.
- R2: pin_oe[i] is the inverse of direction bit i. Direction 1 means input, so the pad is not driven. Direction 0 means output, so the pad is driven.
- R3: A read of address 0 returns the pin levels XORed with the polarity bits, whatever the direction. Each level passes through a two-flop synchronizer, so a pin change first shows on the second rising edge after it.
- R4: A read of address 1 returns the stored output data bits, not the pin level.
- R5: pin_out[i] equals output data bit i XOR polarity bit i. With style bit i at 0, the data bit holds whatever was last written.
- R6: With style bit i at 1 (pulse mode), writing 1 to data bit i sets it for exactly PULSE_LEN clocks (default 4), after which it clears itself. Writing 1 again during the pulse restarts the count. Writing 0 ends the pulse at once.
- R7: On each clock edge with rst_n low, the snapshot (address 5) takes the synchronized raw pin levels, without polarity, when snap_en is 1. It clears to 0 when snap_en is 0. Outside reset it never changes.
- R8: dev_addr equals snapshot bits 2..0.
- R9: Bit 7 always reads 0 and writes to it are ignored. Writes to addresses 0, 5, 6 and 7 change nothing. Reads of addresses 6 and 7 return 0x00.
- R10: Read data is a combinational function of bus_addr and register state. A write takes effect at the rising edge where bus_wr is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snap_en | input | 1 | Enables the pin snapshot during reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 7 | Pad input levels |
| pin_oe | output | 7 | Per-pin output enable |
| pin_out | output | 7 | Per-pin output value |
| dev_addr | output | 3 | Address bits from the snapshot |

## Verification
The bench checks the pulse length edge by edge. A timer that is off by one, or a data bit that never clears, shows up at address 1 and on pin_out. It also writes 0 and then 1 again in the middle of a pulse, which exposes a design that ignores cancellation or does not restart the count. It changes the pins while the direction is output and while out of reset. A design that gates the input view by direction, skips the synchronizer, or lets the snapshot follow the pins would return wrong values there. It also writes to the read-only addresses, the unused addresses and bit 7, which catches a sloppy address decode.

// File: rtl/gpio_port_pkg.sv
// Package: gpio_port_pkg
// Holds the register addresses that the read path and the write decode share.
// Assumes a 3-bit address bus. Addresses 6 and 7 are unused.
package gpio_port_pkg;
    localparam logic [2:0] ADDR_LEVEL = 3'd0;
    localparam logic [2:0] ADDR_DATA  = 3'd1;
    localparam logic [2:0] ADDR_POL   = 3'd2;
    localparam logic [2:0] ADDR_DIR   = 3'd3;
    localparam logic [2:0] ADDR_STYLE = 3'd4;
    localparam logic [2:0] ADDR_SNAP  = 3'd5;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Two-flop synchronizer for the pad inputs.
// Assumes the flops have no reset, so that they keep sampling while reset is
// held. The reset snapshot depends on that. Outputs are valid two edges after
// time zero.
module gpio_pin_sync #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        stage1_q <= async_in;
        stage2_q <= stage1_q;
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_out_bit.sv
// Module: gpio_out_bit
// One output data bit with its pulse timer.
// A write loads the bit. If the bit is written as 1 while the style bit is set,
// a counter is armed. The bit then clears after PULSE_LEN clocks.
// Assumes PULSE_LEN >= 1. The reset is synchronous and active low.
module gpio_out_bit #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic style_pulse,
    output logic data_q
);
    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Load on a write, otherwise count down and clear the bit at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            cnt_q  <= '0;
        end else if (wr_hit) begin
            data_q <= wr_bit;
            cnt_q  <= (wr_bit && style_pulse) ? CNT_LOAD : '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_LAST;
            if (cnt_q == CNT_LAST) begin
                data_q <= 1'b0;
            end
        end
    end

    // A running pulse timer always holds the data bit high.
    p_timer_holds_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> data_q);

    // The last count clears the bit unless a write intervenes.
    p_timer_ends_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && cnt_q == CNT_LAST) |=> !data_q);

    // With no write and no running pulse, the bit holds its value.
    p_level_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && cnt_q == '0) |=> $stable(data_q));
endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds the polarity, direction and style registers and the reset snapshot,
// and drives the read mux.
// Assumes BUS_W > PIN_W. The upper bus bits are unused: they read as 0 and
// writes to them are dropped. The reset is synchronous and active low.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned         PIN_W    = 7,
    parameter int unsigned         BUS_W    = 8,
    parameter logic [PIN_W-1:0]    POL_INIT = 7'h70,
    parameter logic [PIN_W-1:0]    DIR_INIT = 7'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_en,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [PIN_W-1:0] pin_sync,
    input  logic [PIN_W-1:0] data_bits,
    output logic [PIN_W-1:0] pol_q,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] style_q,
    output logic [PIN_W-1:0] snap_q,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int unsigned PAD_W = BUS_W - PIN_W;

    logic [PIN_W-1:0] rd_bits;

    // Load the configuration registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q   <= POL_INIT;
            dir_q   <= DIR_INIT;
            style_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_POL:   pol_q   <= bus_wdata[PIN_W-1:0];
                ADDR_DIR:   dir_q   <= bus_wdata[PIN_W-1:0];
                ADDR_STYLE: style_q <= bus_wdata[PIN_W-1:0];
                default:    ;
            endcase
        end
    end

    // Capture the synchronized pin levels while reset is held, and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= snap_en ? pin_sync : '0;
        end
    end

    // Select the register that bus_addr names.
    always_comb begin
        case (bus_addr)
            ADDR_LEVEL: rd_bits = pin_sync ^ pol_q;
            ADDR_DATA:  rd_bits = data_bits;
            ADDR_POL:   rd_bits = pol_q;
            ADDR_DIR:   rd_bits = dir_q;
            ADDR_STYLE: rd_bits = style_q;
            ADDR_SNAP:  rd_bits = snap_q;
            default:    rd_bits = '0;
        endcase
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_bits};

    // Outside reset the snapshot does not move.
    p_snap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(snap_q));

    // The upper bus bits read as 0.
    p_upper_bits_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PIN_W] == '0);

    // Unused addresses read as 0.
    p_unused_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_SNAP) |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs
// Top of the GPIO port register bank. It ties together the synchronizer, the
// configuration registers and one output bit with pulse timer per pin, and
// drives the pad controls.
// Assumes a single clock, a synchronous active-low reset, and ADDR_BITS <= PIN_W.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned      PIN_W     = 7,
    parameter int unsigned      BUS_W     = 8,
    parameter int unsigned      ADDR_BITS = 3,
    parameter int unsigned      PULSE_LEN = 4,
    parameter logic [PIN_W-1:0] POL_INIT  = 7'h70,
    parameter logic [PIN_W-1:0] DIR_INIT  = 7'h7F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snap_en,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_W-1:0]     pin_in,
    output logic [PIN_W-1:0]     pin_oe,
    output logic [PIN_W-1:0]     pin_out,
    output logic [ADDR_BITS-1:0] dev_addr
);
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] data_bits;
    logic [PIN_W-1:0] pol_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] style_q;
    logic [PIN_W-1:0] snap_q;
    logic             data_wr;

    gpio_pin_sync #(.WIDTH(PIN_W)) u_sync (
        .clk      (clk),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_cfg_regs #(
        .PIN_W    (PIN_W),
        .BUS_W    (BUS_W),
        .POL_INIT (POL_INIT),
        .DIR_INIT (DIR_INIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_en   (snap_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .data_bits (data_bits),
        .pol_q     (pol_q),
        .dir_q     (dir_q),
        .style_q   (style_q),
        .snap_q    (snap_q),
        .bus_rdata (bus_rdata)
    );

    assign data_wr = bus_wr && (bus_addr == ADDR_DATA);

    // One output bit and one pulse timer per pin.
    for (genvar gi = 0; gi < PIN_W; gi++) begin : g_out
        gpio_out_bit #(.PULSE_LEN(PULSE_LEN)) u_bit (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit      (data_wr),
            .wr_bit      (bus_wdata[gi]),
            .style_pulse (style_q[gi]),
            .data_q      (data_bits[gi])
        );
    end

    assign pin_oe   = ~dir_q;
    assign pin_out  = data_bits ^ pol_q;
    assign dev_addr = snap_q[ADDR_BITS-1:0];

    // A direction write sets the pad enables from the next cycle on.
    p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIR) |=> (pin_oe == ~$past(bus_wdata[PIN_W-1:0])));
endmodule

// File: tb/gpio_port_regs_bench.sv
`timescale 1ns/1ps
// Bench for gpio_port_regs. A behavioural model is stepped on every rising
// edge, and every output is compared with it at each falling edge.
module gpio_port_regs_bench;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snap_en = 1'b0;
    logic [2:0] bus_addr = 3'd1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [6:0] pin_in = 7'h55;
    logic [6:0] pin_oe;
    logic [6:0] pin_out;
    logic [2:0] dev_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    int m_out, m_pol, m_dir, m_sty, m_snap;
    int m_sync[$];
    int m_cnt[7];

    always #4 clk = ~clk;

    gpio_port_regs #(.PULSE_LEN(PL)) u_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .snap_en(snap_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .dev_addr(dev_addr)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata(int a);
        case (a)
            0: return (m_sync[1] ^ m_pol) & 'h7F;  // R3
            1: return m_out;                         // R4
            2: return m_pol;
            3: return m_dir;
            4: return m_sty;
            5: return m_snap;                        // R7
            default: return 0;                       // R9
        endcase
    endfunction

    // Step the model with the inputs sampled at this edge (R10 timing).
    task automatic model_step(bit r, bit se, bit w, int a, int wd, int p);
        int old2;
        old2 = m_sync[1];
        m_sync.push_front(p);
        void'(m_sync.pop_back());
        if (!r) begin
            m_out = 0; m_pol = 'h70; m_dir = 'h7F; m_sty = 0;
            m_snap = se ? old2 : 0;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < 7; i++) begin
                if (w && a == 1) begin
                    if (wd[i]) m_out |= (1 << i); else m_out &= ~(1 << i);
                    m_cnt[i] = (wd[i] && m_sty[i]) ? PL : 0;
                end else if (m_cnt[i] != 0) begin
                    if (m_cnt[i] == 1) m_out &= ~(1 << i);
                    m_cnt[i]--;
                end
            end
            if (w) begin
                case (a)
                    2: m_pol = wd & 'h7F;
                    3: m_dir = wd & 'h7F;
                    4: m_sty = wd & 'h7F;
                    default: ;
                endcase
            end
        end
    endtask

    // Apply inputs, pass one rising edge, then compare at the falling edge.
    task automatic tick(bit r, bit se, bit w, int a, int wd, int p);
        string rtag;
        rst_n = r; snap_en = se; bus_wr = w; bus_addr = 3'(a);
        bus_wdata = 8'(wd); pin_in = 7'(p);
        @(posedge clk);
        model_step(r, se, w, a, wd, p);
        @(negedge clk);
        case (a)
            0: rtag = "R3 level read";
            1: rtag = "R4/R6 data read";
            5: rtag = "R7 snapshot read";
            6, 7: rtag = "R9 unused read";
            default: rtag = "R1 config read";
        endcase
        chk(rtag, int'(bus_rdata), exp_rdata(a));
        chk("R2 pin_oe", int'(pin_oe), (~m_dir) & 'h7F);
        chk("R5/R6 pin_out", int'(pin_out), (m_out ^ m_pol) & 'h7F);
        chk("R8 dev_addr", int'(dev_addr), m_snap & 7);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_sync = '{0, 0};
        m_out = 0; m_pol = 'h70; m_dir = 'h7F; m_sty = 0; m_snap = 0;
        // reset without snapshot (clears it), then with snapshot: R1, R7
        repeat (3) tick(0, 0, 0, 1, 0, 'h55);
        repeat (3) tick(0, 1, 0, 1, 0, 'h55);
        // read every address after reset: R1, R9
        for (int a = 0; a < 8; a++) tick(1, 0, 0, a, 0, 'h55);
        // pin change seen through the synchronizer: R3
        repeat (3) tick(1, 0, 0, 0, 0, 'h2B);
        // outputs: R2, R5, R4
        tick(1, 0, 1, 3, 'h00, 'h2B);
        tick(1, 0, 1, 1, 'h2A, 'h2B);
        tick(1, 0, 0, 1, 0, 'h6C);
        tick(1, 0, 0, 0, 0, 'h6C);
        tick(1, 0, 0, 0, 0, 'h6C);
        tick(1, 0, 1, 2, 'h0F, 'h6C);
        tick(1, 0, 0, 0, 0, 'h13);
        tick(1, 0, 0, 0, 0, 'h13);
        tick(1, 0, 0, 0, 0, 'h13);
        tick(1, 0, 1, 3, 'h5A, 'h13);
        // bit 7 and read-only or unused writes ignored: R9
        tick(1, 0, 1, 1, 'hFF, 'h13);
        tick(1, 0, 1, 3, 'h80, 'h13);
        tick(1, 0, 1, 0, 'h11, 'h13);
        tick(1, 0, 1, 5, 'h00, 'h13);
        tick(1, 0, 1, 6, 'hFF, 'h13);
        tick(1, 0, 1, 7, 'h5A, 'h13);
        for (int a = 0; a < 8; a++) tick(1, 0, 0, a, 0, 'h13);
        // pulse mode: R6
        tick(1, 0, 1, 1, 'h00, 'h13);
        tick(1, 0, 1, 2, 'h00, 'h13);
        tick(1, 0, 1, 4, 'h03, 'h13);
        tick(1, 0, 1, 1, 'h01, 'h13);
        repeat (6) tick(1, 0, 0, 1, 0, 'h13);
        tick(1, 0, 1, 1, 'h03, 'h13);
        repeat (2) tick(1, 0, 0, 1, 0, 'h13);
        tick(1, 0, 1, 1, 'h02, 'h13);
        repeat (6) tick(1, 0, 0, 1, 0, 'h13);
        tick(1, 0, 1, 1, 'h41, 'h13);
        repeat (6) tick(1, 0, 0, 1, 0, 'h13);
        // snapshot frozen outside reset: R7, R8
        repeat (4) tick(1, 0, 0, 5, 0, 'h7E);
        // new snapshot during reset, then cleared with snap_en low: R7, R8
        repeat (4) tick(0, 1, 0, 5, 0, 'h1A);
        repeat (3) tick(1, 0, 0, 5, 0, 'h05);
        repeat (2) tick(0, 0, 0, 5, 0, 'h05);
        repeat (2) tick(1, 0, 0, 5, 0, 'h05);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule